// File: doc/BRIEF.md
# Infrared Receive Symbol Queue with Interrupts

This block is the register-side front end of an infrared receiver. An external run-length sampler measures each mark or space and hands over one symbol byte per finished run, plus a one-cycle strobe when it decides a packet has ended. The block keeps those bytes in a byte-wide queue until software pops them through a data register. It also holds the receiver's control and configuration settings and raises one level interrupt for three events: a byte lost to a full queue, the end of a packet, and the fill level passing a programmable trigger.

Software drives a simple register port with a one-cycle select. Reads are combinational from current state, and writes take effect at the clock edge. A read of the data register removes the oldest byte at that edge. Software reads a status word that shows the live fill count above the pending flags, and clears flags by writing ones to them. The queue depth is a parameter and must be a power of two; the two intended depths are 16 and 64. Software normally sets the trigger to half the depth minus one.

Top module: `ir_rx_frontend`

## Requirements
- R1: After synchronous reset, every register reads zero, the queue is empty, the status word reads zero and `irq` is low.
- R2: Offset 0x00 holds the control bits: global enable in bit 0, receive enable in bit 1, and the mode field in bits 5:4, where 2'b11 selects consumer-IR mode. Offset 0x10 holds the polarity-invert bit in bit 2. All other bits read zero, and the stored values drive `cfg_mode` and `cfg_invert`.
- R3: Bytes leave the queue in the order they arrived. A read of offset 0x20 returns the oldest byte in bits 7:0 with zeros above, and removes that byte.
- R4: A read of offset 0x20 while the queue is empty returns zero and leaves the fill count at zero. Writes to 0x20 have no effect.
- R5: Status bits starting at bit 8 show the live fill count, wide enough to show the full depth (5 bits for a depth of 16).
- R6: A symbol that arrives while the queue is full, with no pop in the same cycle, is dropped and sets the overflow flag in status bit 0.
- R7: A packet-end strobe sets the packet-end flag in status bit 1.
- R8: The data-available flag in status bit 4 sets whenever the fill count is above the trigger level. A set condition wins over a clear in the same cycle.
- R9: A write to offset 0x30 clears each flag whose bit is written as one. Flags written as zero keep their value.
- R10: While global enable or receive enable is low, symbols are not queued and packet-end strobes are ignored.
- R11: `irq` is high exactly when some pending flag has its matching enable bit set.
- R12: Offset 0x2C holds the overflow enable in bit 0, the packet-end enable in bit 1, the data-available enable in bit 4, and the trigger level in the bits starting at bit 8. The field is as wide as the count. Other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_sel` is high and `reg_wr` is low |
| sym_valid | input | 1 | Sampler has a finished symbol byte |
| sym_byte | input | 8 | Symbol byte from the sampler |
| pkt_end | input | 1 | Sampler packet-end strobe |
| cfg_mode | output | 2 | Receiver mode field, passed to the sampler |
| cfg_invert | output | 1 | Input polarity invert, passed to the sampler |
| irq | output | 1 | Level interrupt |

## Verification
A read or write pointer that goes wrong shows up on the next data-register read as a byte out of order. A wrong count shows in the status count field at the next status read, and as a flag that did not set or an overflow that was missed. A flag register that fails to set, or that sets and clears at the wrong time, is visible on `irq` in the cycle after the event, once its enable bit is on. The bench pairs each event with a status read and an `irq` sample, so each such fault shows up within a few cycles of its cause.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_RXCFG = 8'h10;
    localparam logic [7:0] OFS_DATA  = 8'h20;
    localparam logic [7:0] OFS_IEN   = 8'h2C;
    localparam logic [7:0] OFS_STAT  = 8'h30;

    localparam int BIT_OVF   = 0;
    localparam int BIT_PEND  = 1;
    localparam int BIT_AVAIL = 4;
    localparam int CNT_LSB   = 8;

    typedef enum logic [2:0] {
        ACC_NONE, ACC_CTRL, ACC_RXCFG, ACC_DATA, ACC_IEN, ACC_STAT
    } acc_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       rx_on;
        logic       glb_on;
    } ctrl_t;

    typedef struct packed {
        logic avail;
        logic pend;
        logic ovf;
    } flags_t;

    function automatic acc_e decode_ofs(input logic [7:0] a);
        case (a)
            OFS_CTRL:  return ACC_CTRL;
            OFS_RXCFG: return ACC_RXCFG;
            OFS_DATA:  return ACC_DATA;
            OFS_IEN:   return ACC_IEN;
            OFS_STAT:  return ACC_STAT;
            default:   return ACC_NONE;
        endcase
    endfunction

    function automatic logic [31:0] place_flags(input flags_t f);
        logic [31:0] r;
        r = '0;
        r[BIT_OVF]   = f.ovf;
        r[BIT_PEND]  = f.pend;
        r[BIT_AVAIL] = f.avail;
        return r;
    endfunction

    function automatic flags_t pick_flags(input logic [31:0] w);
        flags_t f;
        f.ovf   = w[BIT_OVF];
        f.pend  = w[BIT_PEND];
        f.avail = w[BIT_AVAIL];
        return f;
    endfunction

endpackage

// File: rtl/ir_rx_queue.sv
module ir_rx_queue #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [DW-1:0]    din,
    input  logic             pop,
    output logic [DW-1:0]    dout,
    output logic             empty,
    output logic             full,
    output logic             drop,
    output logic [CNT_W-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && full && !do_pop;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + AW'(1);
            if (do_pop)  rptr <= rptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0));

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == CNT_W'(DEPTH)) && $stable(wptr));

endmodule

// File: rtl/ir_rx_cfg.sv
module ir_rx_cfg
    import ir_rx_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  acc_e             acc,
    input  logic [31:0]      wdata,
    output ctrl_t            ctrl,
    output logic             invert,
    output flags_t           ien,
    output logic [CNT_W-1:0] level
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            invert <= 1'b0;
            ien    <= '0;
            level  <= '0;
        end else if (wr_en) begin
            case (acc)
                ACC_CTRL: begin
                    ctrl.glb_on <= wdata[0];
                    ctrl.rx_on  <= wdata[1];
                    ctrl.mode   <= wdata[5:4];
                end
                ACC_RXCFG: invert <= wdata[2];
                ACC_IEN: begin
                    ien   <= pick_flags(wdata);
                    level <= wdata[CNT_LSB +: CNT_W];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ir_rx_irq.sv
module ir_rx_irq
    import ir_rx_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_ovf,
    input  logic             ev_pend,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    input  logic             clr_en,
    input  flags_t           clr_mask,
    input  flags_t           ien,
    output flags_t           flags,
    output logic             irq
);

    flags_t set_v;

    always_comb begin
        set_v.ovf   = ev_ovf;
        set_v.pend  = ev_pend;
        set_v.avail = (count > level);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            // a set in the same cycle overrides a clear
            flags <= set_v | (flags & ~(clr_en ? clr_mask : flags_t'('0)));
        end
    end

    assign irq = |(flags & ien);

    // R8
    avail_set_chk: assert property (@(posedge clk) disable iff (rst)
        (count > level) |=> flags.avail);

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        ev_ovf |=> flags.ovf);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_en && flags.pend) |=> flags.pend);

endmodule

// File: rtl/ir_rx_frontend.sv
module ir_rx_frontend
    import ir_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        sym_valid,
    input  logic [7:0]  sym_byte,
    input  logic        pkt_end,
    output logic [1:0]  cfg_mode,
    output logic        cfg_invert,
    output logic        irq
);

    acc_e             acc;
    logic             wr_en, rd_en, pop, cap_en;
    ctrl_t            ctrl;
    flags_t           ien, flags;
    logic [CNT_W-1:0] level, count;
    logic [7:0]       head;
    logic             empty, full, drop;

    assign acc    = decode_ofs(reg_addr);
    assign wr_en  = reg_sel && reg_wr;
    assign rd_en  = reg_sel && !reg_wr;
    assign pop    = rd_en && (acc == ACC_DATA);
    assign cap_en = ctrl.glb_on && ctrl.rx_on;

    ir_rx_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .acc(acc), .wdata(reg_wdata),
        .ctrl(ctrl), .invert(cfg_invert), .ien(ien), .level(level)
    );

    ir_rx_queue #(.DEPTH(DEPTH), .DW(8)) u_q (
        .clk(clk), .rst(rst), .push(sym_valid && cap_en), .din(sym_byte),
        .pop(pop), .dout(head), .empty(empty), .full(full), .drop(drop),
        .count(count)
    );

    ir_rx_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst(rst), .ev_ovf(drop), .ev_pend(pkt_end && cap_en),
        .count(count), .level(level),
        .clr_en(wr_en && (acc == ACC_STAT)), .clr_mask(pick_flags(reg_wdata)),
        .ien(ien), .flags(flags), .irq(irq)
    );

    assign cfg_mode = ctrl.mode;

    always_comb begin
        reg_rdata = '0;
        case (acc)
            ACC_CTRL: begin
                reg_rdata[0]   = ctrl.glb_on;
                reg_rdata[1]   = ctrl.rx_on;
                reg_rdata[5:4] = ctrl.mode;
            end
            ACC_RXCFG: reg_rdata[2] = cfg_invert;
            ACC_DATA:  reg_rdata[7:0] = empty ? 8'h00 : head;
            ACC_IEN: begin
                reg_rdata = place_flags(ien);
                reg_rdata[CNT_LSB +: CNT_W] = level;
            end
            ACC_STAT: begin
                reg_rdata = place_flags(flags);
                reg_rdata[CNT_LSB +: CNT_W] = count;
            end
            default: ;
        endcase
    end

    // R10
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !pop) |=> $stable(count));

    // R10
    gate_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !flags.pend) |=> !flags.pend);

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq);

endmodule

// File: tb/sim_ir_rx_frontend.sv
module sim_ir_rx_frontend;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_sel, reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        sym_valid, pkt_end;
    logic [7:0]  sym_byte;
    logic [1:0]  cfg_mode;
    logic        cfg_invert, irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_rx_frontend #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sym_valid(sym_valid), .sym_byte(sym_byte), .pkt_end(pkt_end),
        .cfg_mode(cfg_mode), .cfg_invert(cfg_invert), .irq(irq)
    );

    // {offset, write value, expected readback}
    localparam logic [71:0] VEC [8] = '{
        {8'h00, 32'hFFFF_FFFF, 32'h0000_0033},
        {8'h00, 32'h0000_0030, 32'h0000_0030},
        {8'h10, 32'hFFFF_FFFF, 32'h0000_0004},
        {8'h10, 32'h0000_0000, 32'h0000_0000},
        {8'h2C, 32'hFFFF_FFFF, 32'h0000_1F13},
        {8'h2C, 32'h0000_0700, 32'h0000_0700},
        {8'h20, 32'h0000_00FF, 32'h0000_0000},
        {8'h30, 32'h0000_00FF, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 0; reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1; reg_wr = 0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_sel = 0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        sym_valid = 1; sym_byte = b;
        @(negedge clk);
        sym_valid = 0;
    endtask

    task automatic strobe_end();
        @(negedge clk);
        pkt_end = 1;
        @(negedge clk);
        pkt_end = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  model [32];
        int          head, tail;
        head = 0; tail = 0;
        rst = 1; reg_sel = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        sym_valid = 0; sym_byte = 0; pkt_end = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        rd(8'h00, v); check("R1 ctrl", v, 0);
        rd(8'h2C, v); check("R1 ien", v, 0);
        rd(8'h30, v); check("R1 stat", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R2 R12 R4: register table
        foreach (VEC[i]) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            check("R2/R12/R4 table", v, VEC[i][31:0]);
        end
        check("R2 cfg_mode", {30'b0, cfg_mode}, 32'h3);

        // R10: gating with one enable low
        wr(8'h00, 32'h31);
        push(8'h55); strobe_end();
        wr(8'h00, 32'h32);
        push(8'h56); strobe_end();
        rd(8'h30, v); check("R10 gated", v, 0);

        wr(8'h00, 32'h33);
        wr(8'h2C, 32'h700);
        // R5 R8: push 8 bytes, count 8 above level 7
        for (int i = 0; i < 8; i++) begin
            push(8'h80 + 8'(i)); model[tail] = 8'h80 + 8'(i); tail++;
        end
        rd(8'h30, v); check("R5/R8 count+avail", v, 32'h0810);
        wr(8'h30, 32'h10);
        rd(8'h30, v); check("R8 set wins over clear", v, 32'h0810);

        // R3: order
        for (int i = 0; i < 2; i++) begin
            rd(8'h20, v); check("R3 order", v, {24'b0, model[head]}); head++;
        end
        wr(8'h30, 32'h10);
        rd(8'h30, v); check("R9 clear avail", v, 32'h0600);

        // R6 R11: fill then overflow
        wr(8'h2C, 32'h701);
        for (int i = 0; i < 10; i++) begin
            push(8'h40 + 8'(i)); model[tail] = 8'h40 + 8'(i); tail++;
        end
        check("R11 irq low before ovf", {31'b0, irq}, 0);
        push(8'hEE);
        check("R11 irq on ovf", {31'b0, irq}, 1);
        rd(8'h30, v); check("R6 ovf+count", v, 32'h1011);
        wr(8'h2C, 32'h700);
        check("R11 irq masked", {31'b0, irq}, 0);

        for (int i = 0; i < DEPTH; i++) begin
            rd(8'h20, v); check("R3/R6 drain", v, {24'b0, model[head]}); head++;
        end
        rd(8'h20, v); check("R4 empty read", v, 0);
        rd(8'h30, v); check("R4 count zero", v, 32'h0011);
        wr(8'h30, 32'hFF);
        rd(8'h30, v); check("R9 clear all", v, 0);

        // R7 R9 R11: packet end
        wr(8'h2C, 32'h702);
        strobe_end();
        rd(8'h30, v); check("R7 pend", v, 32'h2);
        check("R11 irq pend", {31'b0, irq}, 1);
        wr(8'h30, 32'h0);
        rd(8'h30, v); check("R9 zero keeps", v, 32'h2);
        wr(8'h30, 32'h2);
        rd(8'h30, v); check("R9 w1c pend", v, 0);
        check("R11 irq after clear", {31'b0, irq}, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule